// File: doc/BRIEF.md
# Packed FP4 to Half-Precision Widener

This block accepts a stream of bytes. Each byte holds two 4-bit E2M1 floating-point codes, and the block turns every code into a 16-bit float. A one-bit format select travels with each input beat. It picks bfloat16 or IEEE binary16 for both results of that beat. Every E2M1 value is exact in both target formats, so no rounding takes place.

The conversion needs no arithmetic. The sign bit moves to bit 15. The exponent and mantissa bits are shifted into place. Normal codes then get a fixed exponent bias added. The single subnormal code is replaced by a signed one-half constant, and a zero magnitude passes through as a signed zero.

The converted pair is captured in one output register. Both sides use a valid/ready handshake. A parameter sets how many input bytes travel in each beat. Each byte yields two output lanes, and lane 0 always sits in the low bits.

Top module: `fp4_pair_widener`

## Requirements
- R1: Input byte k carries element 2k in bits [8k+3:8k] and element 2k+1 in bits [8k+7:8k+4]. Element j appears in out_data[16j+15:16j], so lane 0 is the low half.
- R2: Within a nibble, bit 3 is the sign and bits [2:0] are the magnitude. A magnitude of 3'b000 yields 16'h0000, or 16'h8000 when the sign is set.
- R3: With in_fmt=0 (bfloat16), magnitude codes 2..7 (1, 1.5, 2, 3, 4, 6) yield 3F80, 3FC0, 4000, 4040, 4080 and 40C0 hex, with bit 15 set for a negative sign.
- R4: With in_fmt=1 (binary16), magnitude codes 2..7 yield 3C00, 3E00, 4000, 4200, 4400 and 4600 hex, with bit 15 set for a negative sign.
- R5: Magnitude code 3'b001 (the subnormal 0.5) yields 16'h3F00 in bfloat16 and 16'h3800 in binary16, with the sign in bit 15.
- R6: The format is sampled with each accepted beat and applies to every lane of that beat. Consecutive beats may use different formats.
- R7: in_ready is high exactly when out_valid is low or out_ready is high.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R9: While rst_n is low, out_valid is 0 and in_ready is 1.
- R10: A beat accepted at a clock edge is presented, with out_valid high, right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | 8*BYTES | Packed E2M1 pairs |
| in_fmt | input | 1 | 0 = bfloat16, 1 = binary16 |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32*BYTES | Converted lanes, lane 0 lowest |

## Verification
The bench builds the block with BYTES=1, the default, so each beat carries one byte and two lanes. With one byte per beat, all 256 byte values can be swept exhaustively in both formats. That sweep covers every one of the 16 codes in both nibble positions, including signed zeros and the subnormal code. Random backpressure and format switching from one beat to the next then exercise the stall, hold and per-beat format rules.

// File: rtl/fp4_widen_pkg.sv
package fp4_widen_pkg;
  typedef enum logic {FMT_BF16 = 1'b0, FMT_FP16 = 1'b1} half_fmt_e;

  localparam int unsigned HALF_W       = 16;
  localparam int unsigned CODE_W       = 4;
  localparam int unsigned BF16_MAN_TOP = 6;
  localparam int unsigned FP16_MAN_TOP = 9;
  localparam logic [15:0] BF16_BIAS    = 16'((127 - 1) << 7);
  localparam logic [15:0] FP16_BIAS    = 16'((15 - 1) << 10);
  localparam logic [15:0] BF16_HALF    = 16'h3F00;
  localparam logic [15:0] FP16_HALF    = 16'h3800;
endpackage

// File: rtl/fp4_code_lane.sv
module fp4_code_lane
  import fp4_widen_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  half_fmt_e         fmt,
  output logic [HALF_W-1:0] half
);
  logic [2:0]        mag;
  logic [HALF_W-1:0] sign_w;
  logic [HALF_W-1:0] placed;
  logic [HALF_W-1:0] bias;
  logic [HALF_W-1:0] half_const;

  assign mag    = code[2:0];
  assign sign_w = {code[3], {(HALF_W-1){1'b0}}};

  always_comb begin
    if (fmt == FMT_BF16) begin
      placed     = HALF_W'({mag, BF16_MAN_TOP'(0)});
      bias       = BF16_BIAS;
      half_const = BF16_HALF;
    end else begin
      placed     = HALF_W'({mag, FP16_MAN_TOP'(0)});
      bias       = FP16_BIAS;
      half_const = FP16_HALF;
    end
  end

  always_comb begin
    if (mag == 3'b001) begin
      half = sign_w | half_const;
    end else if (mag[2:1] != 2'b00) begin
      half = (sign_w | placed) + bias;
    end else begin
      half = sign_w;
    end
  end
endmodule

// File: rtl/fp4_hold_reg.sv
module fp4_hold_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         valid_q, valid_d;
  logic [W-1:0] data_q;
  logic         load_en;

  assign up_ready = !valid_q || dn_ready;
  assign load_en  = up_valid && up_ready;

  always_comb begin
    valid_d = valid_q;
    if (load_en) begin
      valid_d = 1'b1;
    end else if (dn_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      data_q <= up_data;
    end
  end

  assign dn_valid = valid_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/fp4_pair_widener.sv
module fp4_pair_widener
  import fp4_widen_pkg::*;
#(
  parameter int unsigned BYTES = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [8*BYTES-1:0]    in_data,
  input  logic                  in_fmt,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [32*BYTES-1:0]   out_data
);
  localparam int unsigned LANES = 2 * BYTES;
  localparam int unsigned OUT_W = LANES * HALF_W;

  half_fmt_e        fmt;
  logic [OUT_W-1:0] conv;

  assign fmt = half_fmt_e'(in_fmt);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    fp4_code_lane u_lane (
      .code (in_data[CODE_W*j +: CODE_W]),
      .fmt  (fmt),
      .half (conv[HALF_W*j +: HALF_W])
    );
  end

  fp4_hold_reg #(.W(OUT_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (conv),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );
endmodule

// File: rtl/fp4_pair_widener_chk.sv
module fp4_pair_widener_chk #(
  parameter int unsigned BYTES = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [8*BYTES-1:0]  in_data,
  input logic                out_valid,
  input logic                out_ready,
  input logic [32*BYTES-1:0] out_data
);
  p_stall_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_idle_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data[15] == $past(in_data[3])));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data[2:0] == 3'b000) |=> (out_data[14:0] == 15'd0));

  p_lane1_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data[31] == $past(in_data[7])));
endmodule

bind fp4_pair_widener fp4_pair_widener_chk #(.BYTES(BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_fp4_pair_widener.sv
`timescale 1ns/1ps
module test_fp4_pair_widener;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        in_fmt;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [31:0] exp_q[$];
  logic [7:0]  src_q[$];
  logic        fmt_q[$];
  logic        prev_stall;
  logic [31:0] prev_data;
  logic        pushed_last;

  fp4_pair_widener #(.BYTES(1)) i_fp4_pair_widener (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_fmt(in_fmt), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] ref_half(input logic [3:0] c, input logic f);
    logic [15:0] m;
    if (!f) begin
      case (c[2:0])
        3'd0: m = 16'h0000; 3'd1: m = 16'h3F00; 3'd2: m = 16'h3F80; 3'd3: m = 16'h3FC0;
        3'd4: m = 16'h4000; 3'd5: m = 16'h4040; 3'd6: m = 16'h4080; default: m = 16'h40C0;
      endcase
    end else begin
      case (c[2:0])
        3'd0: m = 16'h0000; 3'd1: m = 16'h3800; 3'd2: m = 16'h3C00; 3'd3: m = 16'h3E00;
        3'd4: m = 16'h4000; 3'd5: m = 16'h4200; 3'd6: m = 16'h4400; default: m = 16'h4600;
      endcase
    end
    return m | {c[3], 15'd0};
  endfunction

  function automatic string req_of(input logic [3:0] c, input logic f);
    if (c[2:0] == 3'd0) return "R2";
    if (c[2:0] == 3'd1) return "R5";
    return f ? "R4" : "R3";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // one cycle: drive at negedge, evaluate handshake, then let the edge happen
  task automatic step(input logic v, input logic [7:0] d, input logic f, input logic rdy);
    logic [31:0] e;
    logic [7:0]  s;
    logic        sf;
    @(negedge clk);
    // R8: stalled output must be unchanged
    if (prev_stall)
      check(out_valid && out_data == prev_data, "R8", out_data, prev_data);
    // R10: beat taken last edge is visible now
    if (pushed_last)
      check(out_valid == 1'b1, "R10", {31'd0, out_valid}, 32'd1);
    in_valid  = v;
    in_data   = d;
    in_fmt    = f;
    out_ready = rdy;
    #1;
    check(in_ready == (!out_valid || out_ready), "R7", {31'd0, in_ready},
          {31'd0, (!out_valid || out_ready)});
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", out_data, 32'd0);
      end else begin
        e  = exp_q.pop_front();
        s  = src_q.pop_front();
        sf = fmt_q.pop_front();
        check(out_data[15:0] == e[15:0], {req_of(s[3:0], sf), " R1 lane0 R6"},
              {16'd0, out_data[15:0]}, {16'd0, e[15:0]});
        check(out_data[31:16] == e[31:16], {req_of(s[7:4], sf), " R1 lane1 R6"},
              {16'd0, out_data[31:16]}, {16'd0, e[31:16]});
      end
    end
    pushed_last = 1'b0;
    if (in_valid && in_ready) begin
      exp_q.push_back({ref_half(d[7:4], f), ref_half(d[3:0], f)});
      src_q.push_back(d);
      fmt_q.push_back(f);
      pushed_last = 1'b1;
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    prev_stall  = 1'b0;
    prev_data   = '0;
    pushed_last = 1'b0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_data   = 8'd0;
    in_fmt    = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R9", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // directed corner: signed zeros and subnormal in both formats
    step(1'b1, 8'h80, 1'b0, 1'b1);
    step(1'b1, 8'h19, 1'b1, 1'b1);
    step(1'b1, 8'h91, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b1);

    // exhaustive sweep of every byte in both formats, random backpressure
    for (int fm = 0; fm < 2; fm++) begin
      for (int b = 0; b < 256; b++) begin
        step(1'b1, 8'(b), 1'(fm), 1'($urandom_range(0, 3) != 0));
        while (!pushed_last) step(1'b1, 8'(b), 1'(fm), 1'($urandom_range(0, 1)));
      end
    end

    // random traffic with per-beat format changes (R6)
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 3) != 0), 8'($urandom), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 2) != 0));
    end

    // drain
    for (int i = 0; i < 10; i++) step(1'b0, 8'd0, 1'b0, 1'b1);
    check(exp_q.size() == 0, "R10", 32'(exp_q.size()), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule